// File: doc/BRIEF.md
# Serial EEPROM single-byte write sequencer

This block carries out one byte write to a serial EEPROM over a two-wire bus, then keeps probing the device until its internal programming cycle has finished. A client raises a request together with the byte to store; the block answers with a busy level, a one-cycle done pulse on success, or a one-cycle error pulse with a reason code.

The block does not toggle bus wires itself. It issues abstract bit operations to a lower bit engine: generate START, generate STOP, transmit one bit, or sample the acknowledge slot. Each operation is held until the engine reports completion. After the data transfer and its STOP, the block repeatedly issues START plus the device control byte and reads the acknowledge slot. A NACK means the device is still busy and causes another probe. An ACK means the write has landed, and the block closes with a STOP.

Top module: `i2cw_byte_write`

## Requirements
- R1: During and after synchronous reset, busy, done, err and op_valid are low.
- R2: Operations use op_code 0 = START, 1 = STOP, 2 = transmit op_bit, 3 = sample acknowledge. Each operation stays presented, with op_valid high, until op_done is seen. op_rx = 0 at the sampled acknowledge means ACK and 1 means NACK.
- R3: The control byte is sent MSB first as 1010, then the three select bits DEV_SEL (default 000), then 0 for a write. With the defaults this is 0xA0.
- R4: The write transfer is START, the control byte, an acknowledge sample, the data byte from bit 7 down to bit 0, an acknowledge sample, then STOP.
- R5: After the write STOP, each probe is START, the control byte, then an acknowledge sample. A NACKed probe is followed directly by another START and control byte, with no STOP in between.
- R6: An acknowledged probe is followed by STOP. When that STOP completes, done is high for exactly one cycle and busy falls in the same cycle.
- R7: A NACK on the control byte of the write transfer leads to STOP, then an err pulse with err_kind = 1. No data bits are sent.
- R8: A NACK on the data byte leads to STOP, then an err pulse with err_kind = 2. No probe is issued.
- R9: If MAX_POLLS probes in a row are NACKed, the block issues STOP, then an err pulse with err_kind = 3. An ACK on probe number MAX_POLLS still succeeds.
- R10: busy goes high in the cycle after an accepted request. A request raised while busy is ignored, and so is the byte that comes with it: the operation stream and the stored byte are unchanged, and only one completion occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a byte write (taken only when idle) |
| wr_data | input | 8 | Byte to write, captured on acceptance |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_kind | output | 2 | Failure reason: 1 control NACK, 2 data NACK, 3 probe limit |
| op_valid | output | 1 | Bit operation presented to the engine |
| op_code | output | 2 | Bit operation code |
| op_bit | output | 1 | Bit to transmit for op_code 2 |
| op_done | input | 1 | Engine finished the presented operation |
| op_rx | input | 1 | Sampled acknowledge level (0 = ACK) |

## Verification
The bench models the bit engine and records the full operation stream, then compares it with a stream built from the requirements. Bytes with distinct bit patterns (0x5A, 0xC3, 0x01) show that the control and data bytes are sent MSB first and that the stored byte is used. Acknowledge patterns tell the cases apart: immediate ACK, a few NACKed probes, ACK exactly on the last allowed probe, probes NACKed up to the limit, and NACK on the control or the data byte. Together these separate the success path, the repeated-probe path and each error exit. A second request raised in mid-run checks that such a request is ignored.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WBIT  = 2'd2,
    OP_RACK  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_W_START, S_W_CTRL, S_W_CACK, S_W_DATA, S_W_DACK, S_W_STOP,
    S_P_START, S_P_CTRL, S_P_ACK, S_P_STOP, S_E_STOP
  } state_e;

  localparam logic [1:0] ERR_CTRL_NACK = 2'd1;
  localparam logic [1:0] ERR_DATA_NACK = 2'd2;
  localparam logic [1:0] ERR_POLL_LIM  = 2'd3;
endpackage

// File: rtl/i2cw_bit_shifter.sv
module i2cw_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  output logic         cur_bit,
  output logic         last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= load_val;
      cnt <= '0;
    end else if (adv) begin
      sh  <= {sh[W-2:0], 1'b0};
      cnt <= cnt + 1'b1;
    end
  end

  assign cur_bit = sh[W-1];
  assign last    = (cnt == LAST_IDX);

  // R3: a fresh load restarts from the first bit, MSB first
  p_load_msb_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0) && (cur_bit == $past(load_val[W-1])));
endmodule

// File: rtl/i2cw_poll_counter.sv
module i2cw_poll_counter #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [PW-1:0] LIM = PW'(MAX_POLLS - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == LIM);

  // R9: the probe count never passes the configured limit
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (cnt <= LIM) && (cnt != '0 || LIM == '0));
endmodule

// File: rtl/i2cw_byte_write.sv
module i2cw_byte_write
  import i2cw_pkg::*;
#(
  parameter int         MAX_POLLS = 16,
  parameter logic [2:0] DEV_SEL   = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [7:0] wr_data,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [1:0] err_kind,
  output logic       op_valid,
  output logic [1:0] op_code,
  output logic       op_bit,
  input  logic       op_done,
  input  logic       op_rx
);
  localparam logic [7:0] CTRL_BYTE = {4'b1010, DEV_SEL, 1'b0};

  state_e     st;
  op_e        op_q;
  logic [7:0] data_q;
  logic       busy_q, done_q, err_q, valid_q;
  logic [1:0] kind_q;

  logic       step;
  logic       sh_load, sh_adv, sh_bit, sh_last;
  logic [7:0] sh_val;
  logic       pc_clr, pc_inc, pc_limit;

  assign step = valid_q && op_done;

  i2cw_bit_shifter #(.W(8)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(sh_val),
    .adv(sh_adv), .cur_bit(sh_bit), .last(sh_last)
  );

  i2cw_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk(clk), .rst(rst), .clr(pc_clr), .inc(pc_inc), .at_limit(pc_limit)
  );

  always_comb begin
    sh_load = 1'b0;
    sh_adv  = 1'b0;
    sh_val  = CTRL_BYTE;
    pc_clr  = 1'b0;
    pc_inc  = 1'b0;
    case (st)
      S_IDLE:   if (req) begin sh_load = 1'b1; pc_clr = 1'b1; end
      S_W_CTRL, S_W_DATA, S_P_CTRL:
                if (step && !sh_last) sh_adv = 1'b1;
      S_W_CACK: if (step && !op_rx) begin sh_load = 1'b1; sh_val = data_q; end
      S_W_STOP: if (step) sh_load = 1'b1;
      S_P_ACK:  if (step && op_rx && !pc_limit) begin
                  sh_load = 1'b1;
                  pc_inc  = 1'b1;
                end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      op_q    <= OP_START;
      data_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
      kind_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          data_q  <= wr_data;
          busy_q  <= 1'b1;
          valid_q <= 1'b1;
          kind_q  <= '0;
          op_q    <= OP_START;
          st      <= S_W_START;
        end
        S_W_START: if (step) begin op_q <= OP_WBIT; st <= S_W_CTRL; end
        S_W_CTRL:  if (step && sh_last) begin op_q <= OP_RACK; st <= S_W_CACK; end
        S_W_CACK: if (step) begin
          if (op_rx) begin
            op_q <= OP_STOP; kind_q <= ERR_CTRL_NACK; st <= S_E_STOP;
          end else begin
            op_q <= OP_WBIT; st <= S_W_DATA;
          end
        end
        S_W_DATA: if (step && sh_last) begin op_q <= OP_RACK; st <= S_W_DACK; end
        S_W_DACK: if (step) begin
          op_q <= OP_STOP;
          if (op_rx) begin kind_q <= ERR_DATA_NACK; st <= S_E_STOP; end
          else st <= S_W_STOP;
        end
        S_W_STOP:  if (step) begin op_q <= OP_START; st <= S_P_START; end
        S_P_START: if (step) begin op_q <= OP_WBIT; st <= S_P_CTRL; end
        S_P_CTRL:  if (step && sh_last) begin op_q <= OP_RACK; st <= S_P_ACK; end
        S_P_ACK: if (step) begin
          if (!op_rx) begin
            op_q <= OP_STOP; st <= S_P_STOP;
          end else if (pc_limit) begin
            op_q <= OP_STOP; kind_q <= ERR_POLL_LIM; st <= S_E_STOP;
          end else begin
            op_q <= OP_START; st <= S_P_START;
          end
        end
        S_P_STOP: if (step) begin
          valid_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b1; st <= S_IDLE;
        end
        S_E_STOP: if (step) begin
          valid_q <= 1'b0; busy_q <= 1'b0; err_q <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign err_kind = kind_q;
  assign op_valid = valid_q;
  assign op_code  = op_q;
  assign op_bit   = sh_bit;

  // R2: an operation is only presented while a sequence is running
  p_op_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> busy);
  // R2: a presented operation holds until the engine finishes it
  p_op_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_done) |=> op_valid && $stable(op_code));
  // R6: success and failure never coincide, and both end busy
  p_end_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !(done && err) && !busy && $past(busy));
  // R10: every sequence opens with START
  p_open_start_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> op_valid && (op_code == OP_START));
  // R10: the stored byte is frozen while busy
  p_data_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && !err) |=> $stable(data_q));
  // R6: the completing step is always a STOP
  p_end_on_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> $past(op_code == OP_STOP) && $past(op_done));
endmodule

// File: tb/i2cw_byte_write_bench.sv
module i2cw_byte_write_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPOLL      = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [7:0] wr_data = '0;
  logic       busy, done, err, op_valid, op_bit;
  logic [1:0] err_kind, op_code;
  logic       op_done = 1'b0;
  logic       op_rx = 1'b0;

  int checks = 0;
  int fails  = 0;

  int log_op [0:511];
  int exp_op [0:511];
  int log_n = 0;
  int exp_n = 0;
  int rack_n = 0;
  int cfg_cn = 0, cfg_dn = 0, cfg_pn = 0;
  int done_cnt = 0, err_cnt = 0;
  logic [1:0] last_kind = '0;
  bit engine_on = 1'b0;

  i2cw_byte_write #(.MAX_POLLS(NPOLL), .DEV_SEL(3'b000)) u_i2cw_byte_write (
    .clk(clk), .rst(rst), .req(req), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err), .err_kind(err_kind),
    .op_valid(op_valid), .op_code(op_code), .op_bit(op_bit),
    .op_done(op_done), .op_rx(op_rx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bit engine model: an op is encoded as code*2 + bit (bit used for transmit only)
  always @(negedge clk) begin
    if (op_done) begin
      op_done <= 1'b0;
    end else if (engine_on && op_valid) begin
      if (log_n < 512) log_op[log_n] = int'(op_code) * 2 + ((op_code == 2'd2) ? int'(op_bit) : 0);
      log_n = log_n + 1;
      op_rx <= 1'b0;
      if (op_code == 2'd3) begin
        if (rack_n == 0)      op_rx <= (cfg_cn != 0);
        else if (rack_n == 1) op_rx <= (cfg_dn != 0);
        else                  op_rx <= ((rack_n - 2) < cfg_pn);
        rack_n = rack_n + 1;
      end
      op_done <= 1'b1;
    end
    if (done) done_cnt = done_cnt + 1;
    if (err) begin err_cnt = err_cnt + 1; last_kind = err_kind; end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, expv);
    end
  endtask

  task automatic push(input int v);
    exp_op[exp_n] = v;
    exp_n++;
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) push(4 + int'(b[i]));
  endtask

  task automatic push_frame_head();
    push(0);
    push_byte(8'hA0);
    push(6);
  endtask

  task automatic clear_run(input int cn, input int dn, input int pn);
    log_n = 0; exp_n = 0; rack_n = 0;
    cfg_cn = cn; cfg_dn = dn; cfg_pn = pn;
    done_cnt = 0; err_cnt = 0; last_kind = '0;
  endtask

  task automatic fire(input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; wr_data = d;
    @(negedge clk);
    req = 1'b0; wr_data = 8'hFF;
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (done_cnt == 0 && err_cnt == 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, {tag, " watchdog"}, n, 3000);
    repeat (6) @(negedge clk);
  endtask

  task automatic cmp_stream(input string tag);
    int bad = -1;
    for (int i = 0; i < exp_n && i < 512; i++)
      if (bad < 0 && (i >= log_n || log_op[i] != exp_op[i])) bad = i;
    check(log_n == exp_n, {tag, " op count"}, log_n, exp_n);
    if (bad >= 0)
      check(1'b0, {tag, " op stream"}, (bad < log_n) ? log_op[bad] : -1, exp_op[bad]);
    else
      check(1'b1, {tag, " op stream"}, 0, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !op_valid, "R1 during reset",
          {busy, done, err, op_valid}, 0);
    rst = 1'b0;
    engine_on = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && !op_valid, "R1 after reset",
          {busy, done, err, op_valid}, 0);
  endtask

  task automatic t_first_ack();
    clear_run(0, 0, 0);
    push_frame_head(); push_byte(8'h5A); push(6); push(2);
    push_frame_head(); push(2);
    @(negedge clk);
    req = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    req = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    wait_end("R4");
    cmp_stream("R3 R4 R6 immediate ACK");
    check(done_cnt == 1 && err_cnt == 0, "R6 one done pulse", done_cnt, 1);
    check(!busy && !op_valid, "R6 idle after done", busy, 0);
  endtask

  task automatic t_retry_polls();
    clear_run(0, 0, 2);
    push_frame_head(); push_byte(8'hC3); push(6); push(2);
    push_frame_head(); push_frame_head(); push_frame_head(); push(2);
    fire(8'hC3);
    wait_end("R5");
    cmp_stream("R5 repeated probes");
    check(done_cnt == 1 && err_cnt == 0, "R5 done after retries", done_cnt, 1);
  endtask

  task automatic t_last_probe_ack();
    clear_run(0, 0, NPOLL - 1);
    push_frame_head(); push_byte(8'h01); push(6); push(2);
    for (int i = 0; i < NPOLL; i++) push_frame_head();
    push(2);
    fire(8'h01);
    wait_end("R9");
    cmp_stream("R9 ACK on last probe");
    check(done_cnt == 1 && err_cnt == 0, "R9 last probe succeeds", err_cnt, 0);
  endtask

  task automatic t_poll_limit();
    clear_run(0, 0, NPOLL);
    push_frame_head(); push_byte(8'h77); push(6); push(2);
    for (int i = 0; i < NPOLL; i++) push_frame_head();
    push(2);
    fire(8'h77);
    wait_end("R9");
    cmp_stream("R9 probe limit");
    check(err_cnt == 1 && done_cnt == 0, "R9 error pulse", err_cnt, 1);
    check(last_kind == 2'd3, "R9 err_kind", last_kind, 3);
  endtask

  task automatic t_ctrl_nack();
    clear_run(1, 0, 0);
    push_frame_head(); push(2);
    fire(8'hE4);
    wait_end("R7");
    cmp_stream("R7 control NACK");
    check(err_cnt == 1 && last_kind == 2'd1, "R7 err_kind", last_kind, 1);
  endtask

  task automatic t_data_nack();
    clear_run(0, 1, 0);
    push_frame_head(); push_byte(8'h96); push(6); push(2);
    fire(8'h96);
    wait_end("R8");
    cmp_stream("R8 data NACK");
    check(err_cnt == 1 && last_kind == 2'd2, "R8 err_kind", last_kind, 2);
  endtask

  task automatic t_req_while_busy();
    clear_run(0, 0, 1);
    push_frame_head(); push_byte(8'hA5); push(6); push(2);
    push_frame_head(); push_frame_head(); push(2);
    fire(8'hA5);
    repeat (7) @(negedge clk);
    req = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    req = 1'b0;
    wait_end("R10");
    repeat (40) @(negedge clk);
    cmp_stream("R10 request while busy");
    check(done_cnt == 1 && err_cnt == 0, "R10 single completion", done_cnt, 1);
    check(!op_valid && !busy, "R10 no second run", busy, 0);
  endtask

  initial begin
    t_reset();
    t_first_ack();
    t_retry_polls();
    t_last_probe_ack();
    t_poll_limit();
    t_ctrl_nack();
    t_data_nack();
    t_req_while_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL global watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule